// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of rows is addressed by the low bits of the branch's word address, and each row holds one two-bit saturating counter for every value of a short global history. The history records the actual outcomes of the most recently resolved branches. It chooses which counter in the addressed row gives the guess, and it chooses which counter learns when a branch resolves.

The front end drives `pred_pc` and reads `pred_taken` in the same cycle, because the lookup is purely combinational over registered state. The back end reports each resolved branch on the resolve port. That report moves one counter one step toward the real direction and shifts the outcome into the history. Each counter is a four-state machine: strong not-taken (`CTR_SNT`, 00), weak not-taken (`CTR_WNT`, 01), weak taken (`CTR_WT`, 10) and strong taken (`CTR_ST`, 11). A taken outcome moves SNT->WNT->WT->ST and then holds at ST. A not-taken outcome moves ST->WT->WNT->SNT and then holds at SNT. Bit 1 of the state is the predicted direction.

Top module: `corr_bpred`

## Requirements
- R1: `pred_taken` is bit 1 of the counter selected by the current `pred_pc` and history, and it follows a change of `pred_pc` within the same cycle with no clock edge.
- R2: The row is chosen by the full `pred_pc` / `res_pc` value (low IDX_BITS bits of the word address), and training one row leaves every other row unchanged.
- R3: After synchronous active-low reset every counter is weak not-taken (01) and the history is 00, so every lookup predicts not taken.
- R4: A taken resolve moves the selected counter one step up, saturating at 11. A not-taken resolve moves it one step down, saturating at 00.
- R5: Starting from a strong state, the prediction of that counter flips only after two consecutive opposite outcomes.
- R6: Each resolve shifts `res_taken` into history bit 0, and the old bit 0 moves to bit 1. History value h selects counter slot h of the row.
- R7: A resolve writes only the slot selected by the history held before that resolve. The other slots of the same row keep their values.
- R8: While `res_valid` is low, the values on `res_pc` and `res_taken` have no effect on any counter or on the history.
- R9: A lookup and a resolve of the same row and slot in the same cycle return the value held before the update. The new value shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | IDX_BITS | Low bits of the word address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | IDX_BITS | Low bits of the word address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A lookup has no register on its path, so the bench changes `pred_pc` on a falling edge and samples `pred_taken` one time unit later, with no rising edge in between. A resolve takes effect at the first rising edge with `res_valid` high. Both the changed counter and the shifted history are therefore sampled at the next falling edge. The same-cycle case is sampled before that rising edge to see the old value, and again after it to see the new one. The history has no port, so the bench sets it by resolving a scratch row twice and then reads it back through which slot of a trained row answers.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;
endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Saturating two-bit state machine: next state for one outcome
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WNT;
        endcase
    end
endmodule

// File: rtl/bp_hist.sv
module bp_hist #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [HIST_BITS-1:0] hist
);
    logic [HIST_BITS-1:0] hist_nxt;

    generate
        if (HIST_BITS == 1) begin : g_one
            assign hist_nxt = bit_in;
        end else begin : g_many
            assign hist_nxt = {hist[HIST_BITS-2:0], bit_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= hist_nxt;
    end
endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int IDX_BITS  = 12,
    parameter int HIST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_BITS-1:0]   rd_a_idx,
    output ctr_t [(1<<HIST_BITS)-1:0] rd_a_row,
    input  logic [IDX_BITS-1:0]   rd_b_idx,
    output ctr_t [(1<<HIST_BITS)-1:0] rd_b_row,
    input  logic                  wr_en,
    input  logic [IDX_BITS-1:0]   wr_idx,
    input  logic [HIST_BITS-1:0]  wr_slot,
    input  ctr_t                  wr_val
);
    localparam int ROWS  = 1 << IDX_BITS;
    localparam int SLOTS = 1 << HIST_BITS;

    ctr_t [SLOTS-1:0] mem [ROWS];

    assign rd_a_row = mem[rd_a_idx];
    assign rd_b_row = mem[rd_b_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int s = 0; s < SLOTS; s++)
                    mem[r][s] <= CTR_WNT;
        end else if (wr_en) begin
            mem[wr_idx][wr_slot] <= wr_val;
        end
    end
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import bp_pkg::*;
#(
    parameter int IDX_BITS  = 12,
    parameter int HIST_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] pred_pc,
    output logic                pred_taken,
    input  logic                res_valid,
    input  logic [IDX_BITS-1:0] res_pc,
    input  logic                res_taken
);
    localparam int SLOTS = 1 << HIST_BITS;

    logic [HIST_BITS-1:0] hist;
    ctr_t [SLOTS-1:0]     pred_row;
    ctr_t [SLOTS-1:0]     upd_row;
    ctr_t                 pred_state;
    ctr_t                 upd_old;
    ctr_t                 upd_new;

    bp_hist #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist     (hist)
    );

    bp_table #(.IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (pred_pc),
        .rd_a_row (pred_row),
        .rd_b_idx (res_pc),
        .rd_b_row (upd_row),
        .wr_en    (res_valid),
        .wr_idx   (res_pc),
        .wr_slot  (hist),
        .wr_val   (upd_new)
    );

    assign pred_state = pred_row[hist];
    assign upd_old    = upd_row[hist];

    bp_ctr_next u_next (
        .cur   (upd_old),
        .taken (res_taken),
        .nxt   (upd_new)
    );

    always_comb begin
        pred_taken = pred_state[1];
    end
endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
    parameter int IDX_BITS  = 12,
    parameter int HIST_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IDX_BITS-1:0]  pred_pc,
    input logic                 pred_taken,
    input logic                 res_valid,
    input logic                 res_taken,
    input logic [HIST_BITS-1:0] hist,
    input logic [1:0]           upd_old,
    input logic [1:0]           upd_new
);
    p_reset_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hist == '0);

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> hist[0] == $past(res_taken));

    p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hist));

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |->
            ((upd_old != 2'b11 && upd_new == upd_old + 2'b01) ||
             (upd_old == 2'b11 && upd_new == 2'b11)));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |->
            ((upd_old != 2'b00 && upd_new == upd_old - 2'b01) ||
             (upd_old == 2'b00 && upd_new == 2'b00)));

    p_pred_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!res_valid) && $stable(pred_pc)) |-> $stable(pred_taken));
endmodule

bind corr_bpred corr_bpred_chk #(.IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .hist       (hist),
    .upd_old    (upd_old),
    .upd_new    (upd_new)
);

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;
    localparam int IDX_BITS = 12;
    localparam int SCRATCH  = 100;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [IDX_BITS-1:0] pred_pc = '0;
    logic                pred_taken;
    logic                res_valid = 1'b0;
    logic [IDX_BITS-1:0] res_pc = '0;
    logic                res_taken = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference state: counters keyed by row*4+slot, default weak not-taken
    logic [1:0] m_ctr [int];
    logic [1:0] m_hist = 2'b00;

    always #5 clk = ~clk;

    corr_bpred #(.IDX_BITS(IDX_BITS), .HIST_BITS(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .res_valid  (res_valid),
        .res_pc     (res_pc),
        .res_taken  (res_taken)
    );

    function automatic logic [1:0] m_get(int row, logic [1:0] slot);
        int key = row * 4 + int'(slot);
        if (m_ctr.exists(key)) return m_ctr[key];
        return 2'b01;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Lookup: change pred_pc after a falling edge, sample 1 unit later
    task automatic look(int row, string req);
        pred_pc = IDX_BITS'(row);
        #1;
        check(req, pred_taken, m_get(row, m_hist)[1]);
    endtask

    task automatic resolve(int row, logic t);
        logic [1:0] c;
        @(negedge clk);
        res_valid = 1'b1; res_pc = IDX_BITS'(row); res_taken = t;
        @(posedge clk);
        c = m_get(row, m_hist);
        if (t && c != 2'b11) c = c + 2'b01;
        else if (!t && c != 2'b00) c = c - 2'b01;
        m_ctr[row * 4 + int'(m_hist)] = c;
        m_hist = {m_hist[0], t};
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Bring history to h by resolving the scratch row twice
    task automatic steer(logic [1:0] h);
        resolve(SCRATCH, h[1]);
        resolve(SCRATCH, h[0]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        look(0, "R3");
        look(5, "R3");
        look(4095, "R3");
    endtask

    task automatic t_hist_select;
        resolve(5, 1'b1);          // row5 slot0 -> WT, history 01
        look(5, "R6 slot1 answers");   // slot1 still WNT -> 0
        check("R6 expected-not-taken", pred_taken, 1'b0);
        steer(2'b00);
        look(5, "R6 slot0 answers");   // slot0 WT -> 1
        check("R6 expected-taken", pred_taken, 1'b1);
        look(6, "R1 comb switch");     // no clock edge between lookups
        check("R1 row6 not taken", pred_taken, 1'b0);
        look(5, "R1 comb switch back");
        check("R2 row5 vs row6", pred_taken, 1'b1);
    endtask

    task automatic t_hysteresis;
        for (int i = 0; i < 3; i++) begin
            steer(2'b11);
            resolve(20, 1'b1);
        end
        steer(2'b11);
        look(20, "R4 saturate at ST");
        check("R4 ST predicts taken", pred_taken, 1'b1);
        resolve(20, 1'b0);
        steer(2'b11);
        look(20, "R5 one miss keeps taken");
        check("R5 WT still taken", pred_taken, 1'b1);
        resolve(20, 1'b0);
        steer(2'b11);
        look(20, "R5 two misses flip");
        check("R5 WNT not taken", pred_taken, 1'b0);
        for (int i = 0; i < 3; i++) begin
            steer(2'b11);
            resolve(20, 1'b0);
        end
        steer(2'b11);
        resolve(20, 1'b1);          // SNT -> WNT, still not taken
        steer(2'b11);
        look(20, "R4 floor then one up");
        check("R4 WNT after SNT+taken", pred_taken, 1'b0);
        resolve(20, 1'b1);          // WNT -> WT
        steer(2'b11);
        look(20, "R4 step to WT");
    endtask

    task automatic t_isolation;
        steer(2'b00); look(20, "R7 slot0 untouched");
        steer(2'b01); look(20, "R7 slot1 untouched");
        steer(2'b10); look(20, "R7 slot2 untouched");
        steer(2'b11); look(19, "R2 neighbour row");
        look(21, "R2 neighbour row");
        look(20, "R7 slot3 trained");
    endtask

    task automatic t_idle;
        steer(2'b11);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            res_valid = 1'b0; res_pc = 12'd20; res_taken = i[0];
        end
        @(negedge clk);
        look(20, "R8 counter and history held");
        check("R8 slot3 WT taken", pred_taken, 1'b1);
        steer(2'b00);
        look(20, "R8 other slot held");
    endtask

    task automatic t_same_cycle;
        steer(2'b10);
        resolve(30, 1'b1);          // row30 slot2 WNT -> WT, history 01
        steer(2'b10);
        @(negedge clk);
        pred_pc = 12'd30;
        res_valid = 1'b1; res_pc = 12'd30; res_taken = 1'b0;
        #1;
        check("R9 old value before edge", pred_taken, 1'b1);
        @(posedge clk);
        m_ctr[30 * 4 + 2] = 2'b01;
        m_hist = {m_hist[0], 1'b0};
        @(negedge clk);
        res_valid = 1'b0;
        steer(2'b10);
        look(30, "R9 new value next cycle");
        check("R9 WNT after update", pred_taken, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hist_select();
        t_hysteresis();
        t_isolation();
        t_idle();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule